// File: doc/BRIEF.md
# JTAG Test Access Port Core

This block is the controller end of a 1149.1-style test port. A sixteen-state TAP state machine advances on the rising edge of the test clock under the mode-select pin. A 5-bit instruction register is loaded through its own scan path. Decode logic turns the held instruction into the controls that a separate boundary scan chain needs. The block also owns the data registers that are read directly from the port: a 32-bit identification register, a single-bit bypass register and an 8-bit test-control register with separate shift and update stages.

The held instruction picks which register sits between the serial input and the serial output. When the boundary scan chain is selected, its serial output comes back in on `bsr_so`, and the block drives state strobes to that chain. The serial output is registered on the falling test-clock edge, and its enable is active only while a scan is shifting. After a test reset, the identification instruction is already loaded, so a data scan right away returns the identity word.

Top module: `jtag_tap_core`

## Requirements
- R1: While `trst_n` is low and after its release, `tdo_oe` is 0 and no mode control is active. The instruction held after reset is IDCODE (`00001`), so the first data scan returns `ID_VALUE` with bit 0 forced to 1, least significant bit first.
- R2: In Capture-IR the instruction shift stage loads `00001`, and those five bits come out first during the following Shift-IR, LSB first.
- R3: The held instruction, and with it every decoded control, changes only on the falling edge in Update-IR (or in Test-Logic-Reset). Shifting a new opcode and reaching Exit1-IR leaves the controls unchanged.
- R4: BYPASS (`11111`) selects a 1-bit register that captures 0, so a data scan returns 0 followed by the input delayed by one bit.
- R5: Any opcode outside {`00001`,`00010`,`00100`,`00110`,`01001`,`01100`} selects the bypass register, for example `00000` and `10101`.
- R6: HIGHZ (`01001`) selects bypass and sets `tristate_all` and `func_rst_req`, with `clamp_out` low.
- R7: CLAMP (`01100`) selects bypass and sets `clamp_out` and `func_rst_req`, with `tristate_all` low.
- R8: EXTEST (`00100`) sets `sel_bscan` and `func_rst_req`. SAMPLE/PRELOAD (`00010`) sets `sel_bscan` only. In both cases shifted data comes from `bsr_so`, and `bsr_shift` is high in Shift-DR.
- R9: ENABLE_TEST_CTRL (`00110`) selects the 8-bit test-control register. It captures its current update value and shifts LSB first. `test_ctrl` changes only in Update-DR under this instruction; a scan under another instruction leaves it as it was.
- R10: `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR, as registered on the falling edge.
- R11: Five rising edges with `tms` high reach Test-Logic-Reset from any state. This reloads IDCODE, drops all mode controls and clears `test_ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary scan chain |
| tdo | output | 1 | Serial data out, falling-edge registered |
| tdo_oe | output | 1 | Output enable for tdo |
| sel_bscan | output | 1 | Boundary scan chain is the selected data register |
| tristate_all | output | 1 | Request to float all functional outputs |
| clamp_out | output | 1 | Request to drive preloaded fixed output values |
| func_rst_req | output | 1 | Functional reset request |
| bsr_capture | output | 1 | Capture-DR strobe for the chain while it is selected |
| bsr_shift | output | 1 | Shift-DR strobe for the chain while it is selected |
| bsr_update | output | 1 | Update-DR strobe for the chain while it is selected |
| test_ctrl | output | TC_W | Update stage of the test-control register |

## Verification
Two things meet in the last bit of a scan. The final bit shifts on the same rising edge that leaves Shift, and the output enable then drops on the next falling edge. The bench reads that final bit through the whole-word comparisons in the bypass and test-control scans. It then checks that `tdo_oe` is already low in Exit1. The other overlap is between a newly shifted opcode and the controls it will drive. The bench stops in Exit1-IR and shows that the old controls still hold, then shows that they switch on the falling edge of Update-IR.

// File: rtl/jtag_pkg.sv
package jtag_pkg;
   localparam int IR_W = 5;
   localparam int ID_W = 32;

   typedef enum logic [3:0] {
      S_TLR, S_RTI,
      S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR, S_UPDDR,
      S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPDIR
   } tap_st_t;

   localparam logic [IR_W-1:0] OP_IDCODE = 5'b00001;
   localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00010;
   localparam logic [IR_W-1:0] OP_EXTEST = 5'b00100;
   localparam logic [IR_W-1:0] OP_TCTRL  = 5'b00110;
   localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b01001;
   localparam logic [IR_W-1:0] OP_CLAMP  = 5'b01100;
   localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
   localparam logic [IR_W-1:0] IR_CAPVAL = 5'b00001;

   typedef struct packed {
      logic sel_id;
      logic sel_tc;
      logic sel_bsr;
      logic sel_byp;
      logic tristate;
      logic clamp;
      logic frst;
   } dec_t;
endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import jtag_pkg::*;
(
   input  logic    tck,
   input  logic    trst_n,
   input  logic    tms,
   output tap_st_t st
);
   tap_st_t nxt;

   always_comb begin
      unique case (st)
         S_TLR:   nxt = tms ? S_TLR   : S_RTI;
         S_RTI:   nxt = tms ? S_SELDR : S_RTI;
         S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
         S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
         S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
         S_EX1DR: nxt = tms ? S_UPDDR : S_PADR;
         S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
         S_EX2DR: nxt = tms ? S_UPDDR : S_SHDR;
         S_UPDDR: nxt = tms ? S_SELDR : S_RTI;
         S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
         S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
         S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
         S_EX1IR: nxt = tms ? S_UPDIR : S_PAIR;
         S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
         S_EX2IR: nxt = tms ? S_UPDIR : S_SHIR;
         S_UPDIR: nxt = tms ? S_SELDR : S_RTI;
         default: nxt = S_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) st <= S_TLR;
      else         st <= nxt;
   end
endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
   import jtag_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_st_t         st,
   output logic [IR_W-1:0] ir_sr,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so,
   output dec_t            dec
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)          ir_sr <= IR_CAPVAL;
      else if (st == S_CAPIR) ir_sr <= IR_CAPVAL;
      else if (st == S_SHIR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)            ir_q <= OP_IDCODE;
      else if (st == S_TLR)   ir_q <= OP_IDCODE;
      else if (st == S_UPDIR) ir_q <= ir_sr;
   end

   assign ir_so = ir_sr[0];

   always_comb begin
      dec = '0;
      unique case (ir_q)
         OP_IDCODE: dec.sel_id  = 1'b1;
         OP_SAMPLE: dec.sel_bsr = 1'b1;
         OP_EXTEST: begin dec.sel_bsr = 1'b1; dec.frst = 1'b1; end
         OP_TCTRL:  dec.sel_tc  = 1'b1;
         OP_HIGHZ:  begin dec.sel_byp = 1'b1; dec.tristate = 1'b1; dec.frst = 1'b1; end
         OP_CLAMP:  begin dec.sel_byp = 1'b1; dec.clamp = 1'b1; dec.frst = 1'b1; end
         default:   dec.sel_byp = 1'b1;
      endcase
   end
endmodule

// File: rtl/jtag_dr_path.sv
module jtag_dr_path
   import jtag_pkg::*;
#(
   parameter logic [ID_W-1:0] ID_VALUE   = 32'h0BAD_F00E,
   parameter int              TC_W       = 8,
   parameter bit              TC_CAP_LIVE = 1'b1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_st_t         st,
   input  dec_t            dec,
   input  logic            bsr_so,
   output logic            dr_so,
   output logic [TC_W-1:0] test_ctrl
);
   localparam logic [ID_W-1:0] ID_CAP = ID_VALUE | {{(ID_W-1){1'b0}}, 1'b1};

   logic [ID_W-1:0] id_sr;
   logic            byp_sr;
   logic [TC_W-1:0] tc_sr;
   logic [TC_W-1:0] tc_cap;

   wire cap = (st == S_CAPDR);
   wire sh  = (st == S_SHDR);

   generate
      if (TC_CAP_LIVE) begin : g_cap_live
         assign tc_cap = test_ctrl;
      end else begin : g_cap_zero
         assign tc_cap = '0;
      end
   endgenerate

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                id_sr <= ID_CAP;
      else if (cap && dec.sel_id) id_sr <= ID_CAP;
      else if (sh && dec.sel_id)  id_sr <= {tdi, id_sr[ID_W-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 byp_sr <= 1'b0;
      else if (cap && dec.sel_byp) byp_sr <= 1'b0;
      else if (sh && dec.sel_byp)  byp_sr <= tdi;
   end

   generate
      if (TC_W == 1) begin : g_tc_one
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                tc_sr <= '0;
            else if (cap && dec.sel_tc) tc_sr <= tc_cap;
            else if (sh && dec.sel_tc)  tc_sr <= tdi;
         end
      end else begin : g_tc_wide
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                tc_sr <= '0;
            else if (cap && dec.sel_tc) tc_sr <= tc_cap;
            else if (sh && dec.sel_tc)  tc_sr <= {tdi, tc_sr[TC_W-1:1]};
         end
      end
   endgenerate

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                            test_ctrl <= '0;
      else if (st == S_TLR)                   test_ctrl <= '0;
      else if (st == S_UPDDR && dec.sel_tc)   test_ctrl <= tc_sr;
   end

   always_comb begin
      if (dec.sel_id)       dr_so = id_sr[0];
      else if (dec.sel_tc)  dr_so = tc_sr[0];
      else if (dec.sel_bsr) dr_so = bsr_so;
      else                  dr_so = byp_sr;
   end
endmodule

// File: rtl/jtag_tap_core.sv
module jtag_tap_core
   import jtag_pkg::*;
#(
   parameter logic [31:0] ID_VALUE    = 32'h0BAD_F00E,
   parameter int          TC_W        = 8,
   parameter bit          TC_CAP_LIVE = 1'b1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   input  logic            bsr_so,
   output logic            tdo,
   output logic            tdo_oe,
   output logic            sel_bscan,
   output logic            tristate_all,
   output logic            clamp_out,
   output logic            func_rst_req,
   output logic            bsr_capture,
   output logic            bsr_shift,
   output logic            bsr_update,
   output logic [TC_W-1:0] test_ctrl
);
   generate
      if (TC_W < 1 || TC_W > 32) begin : g_bad_tcw
         $error("jtag_tap_core: TC_W must lie in 1..32");
      end
   endgenerate

   tap_st_t         st;
   logic [IR_W-1:0] ir_sr;
   logic [IR_W-1:0] ir_q;
   logic            ir_so;
   logic            dr_so;
   dec_t            dec;

   jtag_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(st));

   jtag_ir u_ir (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st),
      .ir_sr(ir_sr), .ir_q(ir_q), .ir_so(ir_so), .dec(dec)
   );

   jtag_dr_path #(.ID_VALUE(ID_VALUE), .TC_W(TC_W), .TC_CAP_LIVE(TC_CAP_LIVE)) u_dr (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .st(st), .dec(dec),
      .bsr_so(bsr_so), .dr_so(dr_so), .test_ctrl(test_ctrl)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (st == S_SHIR) ? ir_so : dr_so;
         tdo_oe <= (st == S_SHIR) || (st == S_SHDR);
      end
   end

   assign sel_bscan    = dec.sel_bsr;
   assign tristate_all = dec.tristate;
   assign clamp_out    = dec.clamp;
   assign func_rst_req = dec.frst;
   assign bsr_capture  = dec.sel_bsr && (st == S_CAPDR);
   assign bsr_shift    = dec.sel_bsr && (st == S_SHDR);
   assign bsr_update   = dec.sel_bsr && (st == S_UPDDR);
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
   import jtag_pkg::*;
(
   input logic            tck,
   input logic            trst_n,
   input tap_st_t         st,
   input logic [IR_W-1:0] ir_q,
   input logic [IR_W-1:0] ir_sr,
   input logic            tdo_oe,
   input logic            sel_bscan,
   input logic            tristate_all,
   input logic            clamp_out,
   input logic            func_rst_req
);
   a_r2_capture_ir: assert property (@(posedge tck) disable iff (!trst_n)
      (st == S_CAPIR) |=> (ir_sr == IR_CAPVAL));

   a_r3_ir_holds: assert property (@(posedge tck) disable iff (!trst_n)
      (st != S_UPDIR && st != S_TLR) |-> $stable(ir_q));

   a_r6_highz_resets: assert property (@(posedge tck) disable iff (!trst_n)
      tristate_all |-> (func_rst_req && !clamp_out && !sel_bscan));

   a_r7_clamp_resets: assert property (@(posedge tck) disable iff (!trst_n)
      clamp_out |-> (func_rst_req && !tristate_all && !sel_bscan));

   a_r8_extest_ctl: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_q == OP_EXTEST) |-> (sel_bscan && func_rst_req));

   a_r10_oe_window: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == ((st == S_SHIR) || (st == S_SHDR)));

   a_r11_tlr_idcode: assert property (@(posedge tck) disable iff (!trst_n)
      (st == S_TLR) |-> (ir_q == OP_IDCODE && !func_rst_req));
endmodule

bind jtag_tap_core jtag_tap_chk u_chk (
   .tck(tck), .trst_n(trst_n), .st(st), .ir_q(ir_q), .ir_sr(ir_sr),
   .tdo_oe(tdo_oe), .sel_bscan(sel_bscan), .tristate_all(tristate_all),
   .clamp_out(clamp_out), .func_rst_req(func_rst_req)
);

// File: tb/sim_jtag_tap_core.sv
module sim_jtag_tap_core;
   localparam logic [31:0] ID = 32'h0BAD_F00E;

   logic tck = 0, trst_n = 0, tms = 1, tdi = 0, bsr_so = 0;
   logic tdo, tdo_oe, sel_bscan, tristate_all, clamp_out, func_rst_req;
   logic bsr_capture, bsr_shift, bsr_update;
   logic [7:0] test_ctrl;
   int checks = 0, errors = 0;
   bit done = 0;

   jtag_tap_core #(.ID_VALUE(ID)) u0 (.*);

   always #4 tck = ~tck;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clk(input logic m, input logic d, output logic s);
      tms = m; tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1 s = tdo;
   endtask

   task automatic shift_ir(input logic [4:0] op, output logic [4:0] cap);
      logic s;
      clk(1,0,s); clk(1,0,s); clk(0,0,s); clk(0,0,s);
      for (int i = 0; i < 5; i++) begin cap[i] = s; clk(i == 4, op[i], s); end
      clk(1,0,s); clk(0,0,s);
   endtask

   task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
      logic s;
      dout = '0;
      clk(1,0,s); clk(0,0,s); clk(0,0,s);
      for (int i = 0; i < n; i++) begin dout[i] = s; clk(i == n-1, din[i], s); end
      clk(1,0,s); clk(0,0,s);
   endtask

   task automatic load(input logic [4:0] op);
      logic [4:0] c;
      shift_ir(op, c);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 oe in reset", {31'b0, tdo_oe}, 0);
      #20 trst_n = 1;
      @(negedge tck); #1;
      chk("R1 controls after reset", {sel_bscan, tristate_all, clamp_out, func_rst_req}, 0);
      chk("R1 oe after reset", {31'b0, tdo_oe}, 0);
      begin logic s; clk(0,0,s); end
      shift_dr(32, 0, d);
      chk("R1 idcode bit0 forced", d, ID | 32'h1);
   endtask

   task automatic t_ir_capture;
      logic [4:0] c;
      shift_ir(5'b11111, c);
      chk("R2 capture-ir value", {27'b0, c}, 32'h1);
   endtask

   task automatic t_bypass(input logic [4:0] op, input string req);
      logic [31:0] d, p;
      load(op);
      p = 32'h0000_00B6;
      shift_dr(8, p, d);
      chk(req, d, {24'b0, p[6:0], 1'b0});
   endtask

   task automatic t_highz;
      logic [31:0] d;
      load(5'b01001);
      chk("R6 highz controls", {sel_bscan, tristate_all, clamp_out, func_rst_req}, 4'b0101);
      shift_dr(4, 32'hD, d);
      chk("R6 highz bypass", d, 32'hA);
   endtask

   task automatic t_clamp;
      logic [31:0] d;
      load(5'b01100);
      chk("R7 clamp controls", {sel_bscan, tristate_all, clamp_out, func_rst_req}, 4'b0011);
      shift_dr(4, 32'h5, d);
      chk("R7 clamp bypass", d, 32'hA);
   endtask

   task automatic t_ir_hold;
      logic s;
      logic [4:0] op;
      op = 5'b01001;
      clk(1,0,s); clk(1,0,s); clk(0,0,s); clk(0,0,s);
      for (int i = 0; i < 5; i++) clk(i == 4, op[i], s);
      chk("R3 old controls held in exit1-ir", {tristate_all, clamp_out}, 2'b01);
      chk("R10 oe low in exit1-ir", {31'b0, tdo_oe}, 0);
      clk(1,0,s);
      chk("R3 controls after update-ir", {tristate_all, clamp_out}, 2'b10);
      clk(0,0,s);
   endtask

   task automatic t_bsr;
      logic s;
      load(5'b00100);
      chk("R8 extest controls", {sel_bscan, func_rst_req}, 2'b11);
      bsr_so = 1;
      clk(1,0,s); clk(0,0,s); clk(0,0,s);
      chk("R8 extest tdo from chain", {30'b0, s, bsr_shift}, 3);
      chk("R10 oe in shift-dr", {31'b0, tdo_oe}, 1);
      bsr_so = 0;
      clk(0,0,s);
      chk("R8 chain low", {31'b0, s}, 0);
      clk(1,0,s); clk(1,0,s);
      chk("R8 update strobe", {31'b0, bsr_update}, 1);
      clk(0,0,s);
      load(5'b00010);
      chk("R8 sample controls", {sel_bscan, func_rst_req}, 2'b10);
   endtask

   task automatic t_tctrl;
      logic [31:0] d;
      load(5'b00110);
      shift_dr(8, 32'hA5, d);
      chk("R9 first capture", d, 0);
      chk("R9 update value", {24'b0, test_ctrl}, 32'hA5);
      shift_dr(8, 32'h3C, d);
      chk("R9 capture live", d, 32'hA5);
      chk("R9 second update", {24'b0, test_ctrl}, 32'h3C);
      load(5'b11111);
      shift_dr(8, 32'hFF, d);
      chk("R9 other scan leaves value", {24'b0, test_ctrl}, 32'h3C);
   endtask

   task automatic t_tms_reset;
      logic s;
      logic [31:0] d;
      load(5'b01001);
      clk(1,0,s); clk(0,0,s); clk(0,0,s);
      for (int i = 0; i < 5; i++) clk(1,0,s);
      chk("R11 controls cleared", {sel_bscan, tristate_all, clamp_out, func_rst_req}, 0);
      chk("R11 test_ctrl cleared", {24'b0, test_ctrl}, 0);
      clk(0,0,s);
      shift_dr(32, 0, d);
      chk("R11 idcode reloaded", d, ID | 32'h1);
   endtask

   initial begin
      t_reset;
      t_ir_capture;
      t_bypass(5'b11111, "R4 bypass 1-bit delay");
      t_bypass(5'b00000, "R5 unassigned 00000");
      t_bypass(5'b10101, "R5 unassigned 10101");
      t_highz;
      t_clamp;
      t_ir_hold;
      t_bsr;
      t_tctrl;
      t_tms_reset;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule